// File: doc/BRIEF.md
# CAN Transmit Mailbox Priority Arbiter

This block holds a small bank of transmit mailboxes (numbered 12 to 15 by default). Each mailbox stores a 4-bit priority, a frame identifier, a data length code, a remote-frame flag and eight data bytes. Software writes these through a simple register write port. Writing the control word with the transfer-command bit set arms the mailbox. Arming is accepted only when the mailbox is in transmit mode and ready.

Whenever the frame transmitter is idle, the arbiter chooses one armed mailbox. The lowest priority value is the most urgent. Equal values go to the lowest mailbox number. The arbiter pulses a start strobe and presents that mailbox's frame fields until the transmitter answers with done or abort. A mailbox that has been handed over is never pre-empted. On the answer, the mailbox becomes ready again, its abort flag records how the transfer ended, and a one-cycle completion event fires on its bit.

Top module: `can_tx_mb_arbiter`

## Requirements
- R1: After reset every mailbox reports ready=1 and abort=0. No start strobe and no completion event are active.
- R2: A write to register select 4 (control) with bit 23 set arms the mailbox, provided its mode is transmit (3) and it is ready. The arm latches the remote flag from bit 20 and the length code from bits 19:16. Ready reads 0 from the next cycle on. The start strobe for that mailbox follows one cycle later, when the transmitter is idle. The frame outputs then carry the stored fields: identifier bits 29:0, remote flag, length code, and data with bytes 0-3 (select 2) in bits 31:0 and bytes 4-7 (select 3) in bits 63:32.
- R3: Among armed mailboxes, the one with the numerically lowest priority is started first. Priority is held in bits 19:16 of a select-0 (mode) write; mode is in bits 26:24.
- R4: Armed mailboxes with equal priority start in ascending mailbox number.
- R5: While a mailbox is with the transmitter, no other start is issued, whatever its priority, until done or abort arrives.
- R6: A done (tx_done_i) sets that mailbox's ready to 1 and its abort to 0. It also pulses that mailbox's event bit for exactly one cycle, one cycle after done.
- R7: An abort (tx_abort_i, which wins over done) sets ready to 1 and abort to 1, with the same event pulse. The abort flag clears when the mailbox is next armed.
- R8: An identifier write (select 1) is accepted only while the mailbox mode is 0 (disabled), and is ignored otherwise.
- R9: A transfer command to a mailbox whose mode is not transmit is ignored: ready stays 1 and no start occurs.
- R10: Writes to mailbox numbers outside the bank are ignored. So are mode, data and control writes to a mailbox that is not ready.
- R11: A done or abort while no mailbox is with the transmitter has no effect: no event fires and no status changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_mb_i | input | 4 | Target mailbox number |
| wr_reg_i | input | 3 | Register select: 0 mode, 1 identifier, 2 data low, 3 data high, 4 control |
| wr_data_i | input | 32 | Write data |
| tx_start_o | output | 1 | One-cycle start strobe to the transmitter |
| tx_mb_o | output | 4 | Mailbox number being transmitted |
| tx_id_o | output | 30 | Identifier word of the frame in flight |
| tx_rtr_o | output | 1 | Remote-frame flag of the frame in flight |
| tx_dlc_o | output | 4 | Data length code of the frame in flight |
| tx_data_o | output | 64 | Data bytes of the frame in flight |
| tx_done_i | input | 1 | Transmitter reports successful completion |
| tx_abort_i | input | 1 | Transmitter reports a cancelled transfer |
| mb_ready_o | output | 4 | Per-mailbox ready status |
| mb_abort_o | output | 4 | Per-mailbox abort status |
| mb_event_o | output | 4 | Per-mailbox one-cycle completion event |

## Verification
A corrupted pending bit or a corrupted priority field shows up as a start strobe in the wrong order, or as a missing or extra start. The scoreboard sees this at the very next grant. A stale busy flag or a stale in-flight index shows up as a second start during a transfer, or as an event on the wrong bit. Either is caught in the cycle the transmitter answers. A lock that fails to hold a mailbox's registers appears as altered frame fields when that mailbox is finally started.

// File: rtl/can_txmb_pkg.sv
package can_txmb_pkg;
  localparam int ID_W   = 30;
  localparam int DLC_W  = 4;
  localparam int DATA_W = 64;
  localparam int MODE_W = 3;

  localparam int MODE_LSB = 24;
  localparam int PRIO_LSB = 16;
  localparam int CMD_BIT  = 23;
  localparam int RTR_BIT  = 20;
  localparam int DLC_LSB  = 16;

  localparam logic [MODE_W-1:0] MODE_OFF = 3'd0;
  localparam logic [MODE_W-1:0] MODE_TX  = 3'd3;

  typedef enum logic [2:0] {
    REG_MODE = 3'd0,
    REG_ID   = 3'd1,
    REG_DLO  = 3'd2,
    REG_DHI  = 3'd3,
    REG_CTRL = 3'd4
  } reg_sel_e;

  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic              rtr;
    logic [DLC_W-1:0]  dlc;
    logic [DATA_W-1:0] data;
  } frame_t;
endpackage

// File: rtl/can_txmb_slot.sv
module can_txmb_slot
  import can_txmb_pkg::*;
#(
  parameter int PRIO_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  reg_sel_e          wr_reg_i,
  input  logic [31:0]       wr_data_i,
  input  logic              grant_i,
  input  logic              fin_i,
  input  logic              abt_i,
  output logic [PRIO_W-1:0] prio_o,
  output logic              pend_o,
  output logic              ready_o,
  output logic              abort_o,
  output frame_t            frame_o
);
  logic [MODE_W-1:0] mode_q;
  logic [PRIO_W-1:0] prio_q;
  logic [ID_W-1:0]   id_q;
  logic [DLC_W-1:0]  dlc_q;
  logic              rtr_q;
  logic [31:0]       dlo_q, dhi_q;
  logic              ready_q, abort_q, pend_q;
  logic              arm;

  assign arm = wr_en_i && (wr_reg_i == REG_CTRL) && wr_data_i[CMD_BIT]
               && (mode_q == MODE_TX) && ready_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_OFF;
      prio_q  <= '0;
      id_q    <= '0;
      dlc_q   <= '0;
      rtr_q   <= 1'b0;
      dlo_q   <= '0;
      dhi_q   <= '0;
      ready_q <= 1'b1;
      abort_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      if (fin_i) begin
        ready_q <= 1'b1;
        abort_q <= abt_i;
      end else if (arm) begin
        ready_q <= 1'b0;
        abort_q <= 1'b0;
        pend_q  <= 1'b1;
        dlc_q   <= wr_data_i[DLC_LSB +: DLC_W];
        rtr_q   <= wr_data_i[RTR_BIT];
      end
      if (grant_i) pend_q <= 1'b0;
      if (wr_en_i && ready_q) begin
        case (wr_reg_i)
          REG_MODE: begin
            mode_q <= wr_data_i[MODE_LSB +: MODE_W];
            prio_q <= wr_data_i[PRIO_LSB +: PRIO_W];
          end
          REG_DLO: dlo_q <= wr_data_i;
          REG_DHI: dhi_q <= wr_data_i;
          default: ;
        endcase
      end
      // identifier only writable while disabled
      if (wr_en_i && (wr_reg_i == REG_ID) && (mode_q == MODE_OFF))
        id_q <= wr_data_i[ID_W-1:0];
    end
  end

  assign prio_o  = prio_q;
  assign pend_o  = pend_q;
  assign ready_o = ready_q;
  assign abort_o = abort_q;
  assign frame_o = '{id: id_q, rtr: rtr_q, dlc: dlc_q, data: {dhi_q, dlo_q}};

  p_arm_drops_ready_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm |=> (!ready_o && pend_o && !abort_o));

  p_fin_restores_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_i |=> (ready_o && (abort_o == $past(abt_i))));

  p_id_locked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != MODE_OFF) |=> $stable(id_q));

  p_pend_not_ready_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_o |-> !ready_o);
endmodule

// File: rtl/can_txmb_pick.sv
module can_txmb_pick #(
  parameter int N      = 4,
  parameter int PRIO_W = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]             req_i,
  input  logic [N-1:0][PRIO_W-1:0] prio_i,
  output logic                     any_o,
  output logic [IDX_W-1:0]         idx_o
);
  logic [PRIO_W-1:0] best;

  // strict less-than keeps the lower index on a tie
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    best  = '1;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && (!any_o || (prio_i[i] < best))) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
        best  = prio_i[i];
      end
    end
  end
endmodule

// File: rtl/can_tx_mb_arbiter.sv
module can_tx_mb_arbiter
  import can_txmb_pkg::*;
#(
  parameter int NUM_MB  = 4,
  parameter int MB_BASE = 12,
  parameter int MBN_W   = 4,
  parameter int PRIO_W  = 4,
  localparam int IDX_W  = (NUM_MB > 1) ? $clog2(NUM_MB) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [MBN_W-1:0]   wr_mb_i,
  input  logic [2:0]         wr_reg_i,
  input  logic [31:0]        wr_data_i,
  output logic               tx_start_o,
  output logic [MBN_W-1:0]   tx_mb_o,
  output logic [ID_W-1:0]    tx_id_o,
  output logic               tx_rtr_o,
  output logic [DLC_W-1:0]   tx_dlc_o,
  output logic [DATA_W-1:0]  tx_data_o,
  input  logic               tx_done_i,
  input  logic               tx_abort_i,
  output logic [NUM_MB-1:0]  mb_ready_o,
  output logic [NUM_MB-1:0]  mb_abort_o,
  output logic [NUM_MB-1:0]  mb_event_o
);
  logic [MBN_W:0]                off_w;
  logic                          hit;
  logic [NUM_MB-1:0]             pend, grant, fin;
  logic [NUM_MB-1:0][PRIO_W-1:0] prio;
  frame_t                        frames [NUM_MB];
  logic                          any;
  logic [IDX_W-1:0]              pick;
  logic                          busy_q, start_q;
  logic [IDX_W-1:0]              cur_q;
  logic [NUM_MB-1:0]             event_q;
  logic                          answer;

  assign off_w  = {1'b0, wr_mb_i} - (MBN_W+1)'(MB_BASE);
  assign hit    = !off_w[MBN_W] && (off_w < (MBN_W+1)'(NUM_MB));
  assign answer = busy_q && (tx_done_i || tx_abort_i);

  for (genvar k = 0; k < NUM_MB; k++) begin : g_slot
    logic sel_wr;
    assign sel_wr   = wr_en_i && hit && (off_w[IDX_W-1:0] == IDX_W'(k));
    assign grant[k] = !busy_q && any && (pick == IDX_W'(k));
    assign fin[k]   = answer && (cur_q == IDX_W'(k));

    can_txmb_slot #(.PRIO_W(PRIO_W)) i_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (sel_wr),
      .wr_reg_i  (reg_sel_e'(wr_reg_i)),
      .wr_data_i (wr_data_i),
      .grant_i   (grant[k]),
      .fin_i     (fin[k]),
      .abt_i     (tx_abort_i),
      .prio_o    (prio[k]),
      .pend_o    (pend[k]),
      .ready_o   (mb_ready_o[k]),
      .abort_o   (mb_abort_o[k]),
      .frame_o   (frames[k])
    );

    p_pick_min_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!busy_q && pend[k]) |-> (any && (prio[pick] <= prio[k])));

    p_tie_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!busy_q && pend[k] && (prio[pick] == prio[k])) |-> (pick <= IDX_W'(k)));
  end

  can_txmb_pick #(.N(NUM_MB), .PRIO_W(PRIO_W)) i_pick (
    .req_i  (pend),
    .prio_i (prio),
    .any_o  (any),
    .idx_o  (pick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      start_q <= 1'b0;
      cur_q   <= '0;
      event_q <= '0;
    end else begin
      start_q <= 1'b0;
      event_q <= '0;
      if (!busy_q && any) begin
        busy_q  <= 1'b1;
        start_q <= 1'b1;
        cur_q   <= pick;
      end else if (answer) begin
        busy_q         <= 1'b0;
        event_q[cur_q] <= 1'b1;
      end
    end
  end

  assign tx_start_o = start_q;
  assign tx_mb_o    = MBN_W'(MB_BASE) + MBN_W'(cur_q);
  assign tx_id_o    = frames[cur_q].id;
  assign tx_rtr_o   = frames[cur_q].rtr;
  assign tx_dlc_o   = frames[cur_q].dlc;
  assign tx_data_o  = frames[cur_q].data;
  assign mb_event_o = event_q;

  p_no_preempt_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !tx_done_i && !tx_abort_i) |=> (busy_q && $stable(cur_q) && !tx_start_o));

  p_event_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(mb_event_o));

  p_idle_answer_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |=> (mb_event_o == '0));

  p_flight_not_ready_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> !mb_ready_o[cur_q]);
endmodule

// File: tb/test_can_tx_mb_arbiter.sv
module test_can_tx_mb_arbiter;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  wr_mb_i = '0;
  logic [2:0]  wr_reg_i = '0;
  logic [31:0] wr_data_i = '0;
  logic        tx_done_i, tx_abort_i;
  logic        tx_start_o, tx_rtr_o;
  logic [3:0]  tx_mb_o, tx_dlc_o, mb_ready_o, mb_abort_o, mb_event_o;
  logic [29:0] tx_id_o;
  logic [63:0] tx_data_o;

  always #4 clk = ~clk;

  can_tx_mb_arbiter i_can_tx_mb_arbiter (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_mb_i(wr_mb_i),
    .wr_reg_i(wr_reg_i), .wr_data_i(wr_data_i), .tx_start_o(tx_start_o),
    .tx_mb_o(tx_mb_o), .tx_id_o(tx_id_o), .tx_rtr_o(tx_rtr_o),
    .tx_dlc_o(tx_dlc_o), .tx_data_o(tx_data_o), .tx_done_i(tx_done_i),
    .tx_abort_i(tx_abort_i), .mb_ready_o(mb_ready_o),
    .mb_abort_o(mb_abort_o), .mb_event_o(mb_event_o)
  );

  typedef struct {
    int          mb;
    logic [29:0] id;
    logic [3:0]  dlc;
    logic        rtr;
    logic [63:0] data;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   total = 0, bad = 0;
  int   done_cnt = 0;
  int   hold = 3;
  bit   abort_flag = 1'b0;
  int   stray_req = 0, stray_seen = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int mb, input int sel, input logic [31:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_mb_i = 4'(mb); wr_reg_i = 3'(sel); wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  function automatic logic [31:0] mode_w(input int m, input int p);
    return (32'(m) << 24) | (32'(p) << 16);
  endfunction

  task automatic setup(input int mb, input int p, input logic [29:0] id,
                       input logic [63:0] d);
    wr(mb, 0, mode_w(0, 0));
    wr(mb, 1, {2'b0, id});
    wr(mb, 0, mode_w(3, p));
    wr(mb, 2, d[31:0]);
    wr(mb, 3, d[63:32]);
  endtask

  task automatic go(input int mb, input int dlc, input bit rtr);
    wr(mb, 4, (32'd1 << 23) | (32'(rtr) << 20) | (32'(dlc) << 16));
  endtask

  function automatic exp_t mk(input int mb, input logic [29:0] id, input int dlc,
                              input bit rtr, input logic [63:0] d, input string tag);
    exp_t e;
    e.mb = mb; e.id = id; e.dlc = 4'(dlc); e.rtr = rtr; e.data = d; e.tag = tag;
    return e;
  endfunction

  // scoreboard monitor + transmitter model
  initial begin
    tx_done_i = 1'b0; tx_abort_i = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_ni && tx_start_o) begin
        int  mbn;
        bit  ab;
        mbn = int'(tx_mb_o);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R5 unexpected start", 64'(tx_mb_o), 64'hFF);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(int'(tx_mb_o) == e.mb, {e.tag, " order"}, 64'(tx_mb_o), 64'(e.mb));
          chk(tx_id_o == e.id, "R2 id", 64'(tx_id_o), 64'(e.id));
          chk(tx_dlc_o == e.dlc && tx_rtr_o == e.rtr, "R2 dlc/rtr",
              64'({tx_rtr_o, tx_dlc_o}), 64'({e.rtr, e.dlc}));
          chk(tx_data_o == e.data, "R2 data", tx_data_o, e.data);
        end
        for (int k = 0; k < hold; k++) begin
          @(negedge clk);
          chk(!tx_start_o, "R5 start during flight", 64'(tx_start_o), 64'd0);
        end
        ab = abort_flag;
        tx_done_i = !ab; tx_abort_i = ab;
        @(negedge clk);
        tx_done_i = 1'b0; tx_abort_i = 1'b0;
        if (mbn >= 12 && mbn <= 15) begin
          chk(mb_event_o == 4'(1 << (mbn - 12)), ab ? "R7 event" : "R6 event",
              64'(mb_event_o), 64'(1 << (mbn - 12)));
          chk(mb_ready_o[mbn-12] == 1'b1, ab ? "R7 ready" : "R6 ready",
              64'(mb_ready_o), 64'(1 << (mbn - 12)));
          chk(mb_abort_o[mbn-12] == ab, ab ? "R7 abort set" : "R6 abort clear",
              64'(mb_abort_o[mbn-12]), 64'(ab));
        end
        done_cnt++;
      end else if (rst_ni && stray_req != stray_seen) begin
        logic [3:0] rdy;
        stray_seen++;
        rdy = mb_ready_o;
        tx_done_i = 1'b1;
        @(negedge clk);
        tx_done_i = 1'b0;
        chk(mb_event_o == 4'd0, "R11 event", 64'(mb_event_o), 64'd0);
        chk(mb_ready_o == rdy, "R11 ready", 64'(mb_ready_o), 64'(rdy));
      end
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] d12, d13, d14, d15;
    logic [29:0] id13;
    d12 = 64'h1122_3344_5566_7788; d13 = 64'hA5A5_0000_FFFF_0101;
    d14 = 64'h0F0E_0D0C_0B0A_0908; d15 = 64'h8000_0000_0000_0001;
    id13 = 30'h0123_4567;

    repeat (3) @(negedge clk);
    chk(mb_ready_o == 4'hF && mb_abort_o == 4'h0, "R1 status",
        64'({mb_ready_o, mb_abort_o}), 64'hF0);
    chk(!tx_start_o && mb_event_o == 4'h0, "R1 idle",
        64'({tx_start_o, mb_event_o}), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(mb_ready_o == 4'hF, "R1 after release", 64'(mb_ready_o), 64'hF);

    // R2 basic send
    hold = 3;
    setup(12, 2, 30'h2000_0123, d12);
    exp_q.push_back(mk(12, 30'h2000_0123, 8, 1'b0, d12, "R2"));
    go(12, 8, 1'b0);
    chk(mb_ready_o[0] == 1'b0, "R2 ready drop", 64'(mb_ready_o), 64'hE);
    wait (done_cnt == 1);

    // R3/R4/R5 ordering; R10 writes to armed mailboxes ignored
    hold = 20;
    setup(15, 9, 30'h0000_0555, d15);
    setup(12, 7, 30'h0000_0111, d12);
    setup(13, 3, id13, d13);
    setup(14, 3, 30'h1555_5555, d14);
    exp_q.push_back(mk(15, 30'h0000_0555, 1, 1'b0, d15, "R5"));
    exp_q.push_back(mk(13, id13, 2, 1'b0, d13, "R3"));
    exp_q.push_back(mk(14, 30'h1555_5555, 3, 1'b0, d14, "R4"));
    exp_q.push_back(mk(12, 30'h0000_0111, 4, 1'b0, d12, "R3 R10"));
    go(15, 1, 1'b0);
    go(12, 4, 1'b0);
    go(13, 2, 1'b0);
    go(14, 3, 1'b0);
    wr(12, 2, 32'hDEAD_BEEF);
    wr(13, 0, mode_w(3, 15));
    wait (done_cnt == 5);

    // R7 abort, then re-arm clears abort
    hold = 2;
    abort_flag = 1'b1;
    setup(14, 0, 30'h0000_0777, d14);
    exp_q.push_back(mk(14, 30'h0000_0777, 5, 1'b0, d14, "R7"));
    go(14, 5, 1'b0);
    wait (done_cnt == 6);
    abort_flag = 1'b0;
    exp_q.push_back(mk(14, 30'h0000_0777, 6, 1'b0, d14, "R7 rearm"));
    go(14, 6, 1'b0);
    chk(mb_abort_o[2] == 1'b0, "R7 abort cleared on arm", 64'(mb_abort_o), 64'h0);
    wait (done_cnt == 7);

    // R8 identifier write ignored in transmit mode; remote frame
    wr(13, 1, 32'h0000_0001);
    exp_q.push_back(mk(13, id13, 0, 1'b1, d13, "R8"));
    go(13, 0, 1'b1);
    wait (done_cnt == 8);

    // R9 command in receive mode ignored
    wr(12, 0, mode_w(1, 0));
    go(12, 8, 1'b0);
    repeat (4) @(negedge clk);
    chk(mb_ready_o[0] == 1'b1, "R9 ready kept", 64'(mb_ready_o), 64'hF);

    // R10 out-of-bank mailbox numbers
    go(5, 8, 1'b0);
    go(11, 8, 1'b0);
    repeat (4) @(negedge clk);
    chk(mb_ready_o == 4'hF, "R10 out of bank", 64'(mb_ready_o), 64'hF);

    // R11 stray answer
    stray_req++;
    repeat (6) @(negedge clk);
    chk(exp_q.size() == 0 && done_cnt == 8, "R5 queue drained",
        64'(exp_q.size()), 64'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule